// File: doc/BRIEF.md
# Select-Load JK Storage Register

This block is a small storage register whose bits are held in explicitly modelled JK flip-flops that share one clock. Two control inputs, a select and a load strobe, are decoded into exactly one of three actions. The actions are: keep the contents, present the contents at the output, or capture the input word on the next rising clock edge. A control unit elsewhere drives the strobes in step with the clock. The block only interprets them.

No tri-state is used. When the register is not presenting its contents, the data output is forced to zero and a valid flag is low. The J and K input of every bit is always actively driven. Both are 0 unless a load is in progress. During a load, J carries the data bit and K its complement, so an idle cycle can never clear a bit.

Top module: `sljk_reg`

## Requirements
- R1: While rst_ni is low, every stored bit is cleared to 0, and a read after reset returns 0.
- R2: With sel_i=0 and load_i=0, out_valid_o is 0, data_o is all zeros, and the stored word is unchanged whatever data_i carries.
- R3: With sel_i=0 and load_i=1, nothing is captured: out_valid_o is 0, data_o is all zeros, and the stored word is unchanged.
- R4: With sel_i=1 and load_i=0, out_valid_o is 1 and data_o equals the stored word in the same cycle. The read leaves the contents unchanged.
- R5: With sel_i=1 and load_i=1, data_i is stored at the rising clock edge. During that cycle out_valid_o is 0 and data_o is all zeros.
- R6: When no load is enabled, every bit receives J=0 and K=0, so K is never 1 outside a load.
- R7: During a load, each bit receives J equal to its data bit and K equal to that bit's complement. J and K are therefore never both 1, and bits can be set as well as cleared.
- R8: Contents survive any number of consecutive non-load cycles, including repeated reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Select strobe |
| load_i | input | 1 | Load strobe |
| data_i | input | WIDTH | Word to capture |
| data_o | output | WIDTH | Stored word when presenting, else zero |
| out_valid_o | output | 1 | High while data_o presents the stored word |

## Verification
The read path is combinational, so out_valid_o and data_o are due in the same cycle the strobes are applied. A captured word first appears on a read issued in the cycle after the load edge. The driver changes the strobes on the falling edge and queues the expected output for that cycle. The monitor samples 1 ns after the same falling edge, which is mid-cycle and before the next rising edge. This lets a back-to-back load then read see the newly stored word exactly one edge later.

// File: rtl/sljk_pkg.sv
package sljk_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DRIVE = 2'd1,
    ACT_LOAD  = 2'd2
  } act_e;
endpackage

// File: rtl/sljk_decode.sv
module sljk_decode
  import sljk_pkg::*;
(
  input  logic sel_i,
  input  logic load_i,
  output logic ld_en_o,
  output logic drv_en_o
);
  act_e act;

  always_comb begin
    unique case ({sel_i, load_i})
      2'b10:   act = ACT_DRIVE;
      2'b11:   act = ACT_LOAD;
      default: act = ACT_HOLD;
    endcase
  end

  assign ld_en_o  = (act == ACT_LOAD);
  assign drv_en_o = (act == ACT_DRIVE);
endmodule

// File: rtl/sljk_gate.sv
module sljk_gate #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             ld_en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] j_o,
  output logic [WIDTH-1:0] k_o
);
  // J=K=0 when idle; never K=1 outside a load
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign j_o[b] = ld_en_i &  d_i[b];
    assign k_o[b] = ld_en_i & ~d_i[b];
  end
endmodule

// File: rtl/sljk_jk_ff.sv
module sljk_jk_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case ({j_i, k_i})
        2'b00: q_o <= q_o;
        2'b10: q_o <= 1'b1;
        2'b01: q_o <= 1'b0;
        2'b11: q_o <= ~q_o;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/sljk_reg.sv
module sljk_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             out_valid_o
);
  logic             ld_en;
  logic             drv_en;
  logic [WIDTH-1:0] j_w;
  logic [WIDTH-1:0] k_w;
  logic [WIDTH-1:0] q_w;

  sljk_decode u_dec (
    .sel_i    (sel_i),
    .load_i   (load_i),
    .ld_en_o  (ld_en),
    .drv_en_o (drv_en)
  );

  sljk_gate #(.WIDTH(WIDTH)) u_gate (
    .ld_en_i (ld_en),
    .d_i     (data_i),
    .j_o     (j_w),
    .k_o     (k_w)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_ff
    sljk_jk_ff u_ff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .j_i    (j_w[b]),
      .k_i    (k_w[b]),
      .q_o    (q_w[b])
    );
  end

  // forced zero instead of a floating bus
  assign data_o      = drv_en ? q_w : '0;
  assign out_valid_o = drv_en;
endmodule

// File: rtl/sljk_reg_chk.sv
module sljk_reg_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             load_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] data_o,
  input logic             out_valid_o,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] j,
  input logic [WIDTH-1:0] k
);
  // R2 R3 R8
  hold_when_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && load_i) |=> $stable(q));

  // R5
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && load_i) |=> (q == $past(data_i)));

  // R4
  drive_shows_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !load_i) |-> (out_valid_o && data_o == q));

  // R2 R3 R5
  idle_out_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !load_i) |-> (!out_valid_o && data_o == '0));

  // R6
  no_k_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && load_i) |-> (j == '0 && k == '0));

  // R7
  jk_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((j & k) == '0));

  // R7
  load_jk_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && load_i) |-> (j == data_i && k == ~data_i));

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (q == '0);
    end
  end
endmodule

bind sljk_reg sljk_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .load_i      (load_i),
  .data_i      (data_i),
  .data_o      (data_o),
  .out_valid_o (out_valid_o),
  .q           (q_w),
  .j           (j_w),
  .k           (k_w)
);

// File: tb/sljk_reg_tb.sv
`timescale 1ns/1ps
module sljk_reg_tb_top;
  localparam int W = 4;

  typedef struct {
    logic         vld;
    logic [W-1:0] dat;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         vld;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  sljk_reg #(.WIDTH(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sel_i       (sel),
    .load_i      (load),
    .data_i      (din),
    .data_o      (dout),
    .out_valid_o (vld)
  );

  task automatic step(input logic s, input logic l, input logic [W-1:0] d,
                      input logic ev, input logic [W-1:0] ed, input string req);
    exp_t e;
    @(negedge clk);
    sel = s; load = l; din = d;
    e.vld = ev; e.dat = ed; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: sample mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_run++;
        if (vld !== e.vld || dout !== e.dat) begin
          n_fail++;
          $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                   e.req, vld, dout, e.vld, e.dat);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_run++;
    if (vld !== 1'b0 || dout !== '0) begin
      n_fail++;
      $display("FAIL R1: got valid=%0b data=%h in reset, expected valid=0 data=0", vld, dout);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 4'h7, 1, 4'h0, "R1");   // read after reset
    step(1, 1, 4'hA, 0, 4'h0, "R5");   // load A, output quiet
    step(1, 0, 4'h0, 1, 4'hA, "R4");
    step(0, 0, 4'hF, 0, 4'h0, "R2");
    step(1, 0, 4'hF, 1, 4'hA, "R2");   // unchanged after idle
    step(0, 1, 4'h5, 0, 4'h0, "R3");
    step(1, 0, 4'h5, 1, 4'hA, "R3");   // not captured
    step(1, 1, 4'h5, 0, 4'h0, "R5");
    step(1, 0, 4'h0, 1, 4'h5, "R7");   // A->5 sets and clears bits
    step(1, 1, 4'h0, 0, 4'h0, "R5");
    step(1, 0, 4'hF, 1, 4'h0, "R7");
    step(1, 1, 4'hF, 0, 4'h0, "R5");
    step(1, 0, 4'h0, 1, 4'hF, "R7");
    for (int i = 0; i < 20; i++) step(0, i[0], ~4'hF, 0, 4'h0, "R6");
    step(1, 0, 4'h0, 1, 4'hF, "R6");
    for (int i = 0; i < 5; i++) step(1, 0, 4'h0, 1, 4'hF, "R8");
    step(1, 1, 4'h6, 0, 4'h0, "R5");
    step(1, 0, 4'h9, 1, 4'h6, "R5");   // back-to-back
    step(0, 0, 4'h0, 0, 4'h0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule